// File: doc/BRIEF.md
# Bundle Dispersal Unit

This block sits between an instruction fetch buffer and the issue ports of a wide in-order core. Each cycle it sees a two-bundle window. Each 128-bit bundle carries three 41-bit instruction slots and a 5-bit template code. The template says which kind of functional unit each slot needs and where an instruction group ends. The block walks the slots in program order. It sends each slot to the lowest-numbered free port of the matching kind. It stops at a group end or at the first slot whose port kind is used up for the cycle. It never compares register operands; the template is the only source of ordering information.

A bundle that cannot go out whole in one cycle stays at the head of the window. A per-slot mask records which of its slots have already left, so the next cycle resumes at the first slot still pending. The second bundle of the window may issue in the same cycle once the head bundle has fully left. The unit tells the fetch side how many bundles to retire from the window (0, 1 or 2). A head bundle with a reserved template raises an error pulse, issues nothing and is retired.

The control is a two-state machine. CLEAN means the head bundle has no slot issued yet. PARTIAL means the head bundle has some slots issued and others pending. The machine moves CLEAN to PARTIAL when the head leaves only part of its slots, or when the head retires and the second bundle leaves part of its slots. It moves PARTIAL to CLEAN when the head completes and no partly issued bundle moves up behind it. It stays in PARTIAL when the head gains slots but is still incomplete, or when the next bundle moves up partly issued. It stays in CLEAN when nothing issues.

Top module: `bdu_top`

## Requirements
- R1: A bundle holds its template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. An issued slot's 41 bits appear unchanged on its port's payload lane.
- R2: Legal template codes 0 to 7 map slots 0/1/2 to unit kinds (M=memory, I=integer, F=float, B=branch) and to a group end after the named slot:
  - 0: M I I, no end
  - 1: M I I, end after slot 2
  - 2: M M I, end after slot 1
  - 3: M F I, no end
  - 4: M M F, end after slot 2
  - 5: M I B, no end
  - 6: M B B, end after slot 0
  - 7: B B B, end after slot 2
- R3: Ports 0–1 are memory, 2–3 integer, 4–5 float and 6–8 branch. A slot goes to the lowest-numbered port of its kind that is free (`port_free` bit set) and not yet taken this cycle. No port is driven valid while its free bit is low.
- R4: Slots are considered in order: bundle 0 slots 0, 1, 2, then bundle 1 slots 0, 1, 2. After a slot that ends a group, nothing more issues that cycle.
- R5: When a slot finds no free port of its kind, it and every later slot wait; no later slot issues ahead of it in that cycle.
- R6: Slots of the head bundle issued in earlier cycles are not issued again. Issue resumes at the first pending slot while the window is held.
- R7: Bundle 1 issues only in a cycle in which bundle 0 completes. `port_src` is 0 for a slot from bundle 0 and 1 for a slot from bundle 1.
- R8: `win_adv` is 2 when both bundles complete in the cycle, 1 when only the head completes, and 0 otherwise.
- R9: A head bundle with a template code from 8 to 31 pulses `bun_err`, issues no slot, and gives `win_adv` = 1.
- R10: A bundle whose valid bit is low issues nothing, and nothing behind it issues.
- R11: After reset, no bundle is treated as partly issued, and with no valid bundle every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bun0 | input | 128 | Head bundle of the window |
| bun1 | input | 128 | Second bundle of the window |
| bun_vld | input | 2 | Valid bits for bun0 (bit 0) and bun1 (bit 1) |
| port_free | input | 9 | Ports able to accept a slot this cycle |
| port_vld | output | 9 | A slot is issued on this port |
| port_insn | output | 369 | 41-bit slot payload per port, port p in bits [41p+40:41p] |
| port_src | output | 9 | Source bundle of each port's slot (0 head, 1 second) |
| win_adv | output | 2 | Number of bundles to retire from the window |
| bun_err | output | 1 | Head bundle has a reserved template |

## Verification
The bench builds the block with its default parameters: 41-bit slots, 2 memory, 2 integer, 2 float and 3 branch ports. Random free masks often leave one unit kind with no port. Templates with two memory or three branch slots then reach port exhaustion in every kind, and the resume path after a partial issue is exercised repeatedly. Reserved codes anywhere in 8–31, and a second bundle whose valid bit drops at random, reach the error retire path and the invalid-bundle halt. Same-cycle issue from both bundles is reached whenever the head's last slot leaves early in a cycle with ports to spare.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
    typedef enum logic [1:0] {
        UK_MEM = 2'd0,
        UK_INT = 2'd1,
        UK_FLT = 2'd2,
        UK_BRN = 2'd3
    } ukind_e;

    // decoded template: legality, unit kind per slot, group end after slot
    typedef struct packed {
        logic            legal;
        logic [2:0][1:0] kind;
        logic [2:0]      stop;
    } tmpl_t;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_PARTIAL = 1'b1
    } disp_st_e;
endpackage

// File: rtl/bdu_tmpl_dec.sv
module bdu_tmpl_dec
    import bdu_pkg::*;
#(
    parameter int TMPL_W = 5
) (
    input  logic [TMPL_W-1:0] code,
    output tmpl_t             dec
);
    always_comb begin
        dec.legal = 1'b1;
        dec.kind  = '0;
        dec.stop  = '0;
        unique case (code)
            TMPL_W'(0): dec.kind = {UK_INT, UK_INT, UK_MEM};
            TMPL_W'(1): begin dec.kind = {UK_INT, UK_INT, UK_MEM}; dec.stop = 3'b100; end
            TMPL_W'(2): begin dec.kind = {UK_INT, UK_MEM, UK_MEM}; dec.stop = 3'b010; end
            TMPL_W'(3): dec.kind = {UK_INT, UK_FLT, UK_MEM};
            TMPL_W'(4): begin dec.kind = {UK_FLT, UK_MEM, UK_MEM}; dec.stop = 3'b100; end
            TMPL_W'(5): dec.kind = {UK_BRN, UK_INT, UK_MEM};
            TMPL_W'(6): begin dec.kind = {UK_BRN, UK_BRN, UK_MEM}; dec.stop = 3'b001; end
            TMPL_W'(7): begin dec.kind = {UK_BRN, UK_BRN, UK_BRN}; dec.stop = 3'b100; end
            default:    dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bdu_slot_steer.sv
module bdu_slot_steer
    import bdu_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int NSLOT  = 3,
    parameter int NBUN   = 2,
    parameter int N_MEM  = 2,
    parameter int N_INT  = 2,
    parameter int N_FLT  = 2,
    parameter int N_BRN  = 3,
    localparam int NPORT  = N_MEM + N_INT + N_FLT + N_BRN,
    localparam int BIDX_W = (NBUN > 1) ? $clog2(NBUN) : 1
) (
    input  logic [NBUN-1:0]                     bvld,
    input  tmpl_t [NBUN-1:0]                    tdec,
    input  logic [NBUN-1:0][NSLOT-1:0][SLOT_W-1:0] slot,
    input  logic [NSLOT-1:0]                    resume,
    input  logic [NPORT-1:0]                    free,
    output logic [NPORT-1:0]                    pvld,
    output logic [NPORT-1:0][SLOT_W-1:0]        pinsn,
    output logic [NPORT-1:0][BIDX_W-1:0]        psrc,
    output logic [NBUN-1:0][NSLOT-1:0]          done,
    output logic                                bad_head
);
    localparam int INT_BASE = N_MEM;
    localparam int FLT_BASE = INT_BASE + N_INT;
    localparam int BRN_BASE = FLT_BASE + N_FLT;

    function automatic logic [1:0] kind_of(input int p);
        if (p < INT_BASE)      return UK_MEM;
        else if (p < FLT_BASE) return UK_INT;
        else if (p < BRN_BASE) return UK_FLT;
        else                   return UK_BRN;
    endfunction

    logic [NPORT-1:0] taken;
    logic             halt;
    logic             found;
    int               pick;

    always_comb begin
        taken    = '0;
        halt     = 1'b0;
        pvld     = '0;
        pinsn    = '0;
        psrc     = '0;
        done     = '0;
        done[0]  = resume;
        bad_head = 1'b0;
        found    = 1'b0;
        pick     = 0;
        for (int b = 0; b < NBUN; b++) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (!halt) begin
                    if (!bvld[b]) begin
                        halt = 1'b1;
                    end else if (!tdec[b].legal) begin
                        halt = 1'b1;
                        if (b == 0) bad_head = 1'b1;
                    end else if (!done[b][k]) begin
                        found = 1'b0;
                        pick  = 0;
                        for (int p = 0; p < NPORT; p++) begin
                            if (!found && free[p] && !taken[p] && kind_of(p) == tdec[b].kind[k]) begin
                                found = 1'b1;
                                pick  = p;
                            end
                        end
                        if (!found) begin
                            halt = 1'b1;
                        end else begin
                            taken[pick] = 1'b1;
                            pvld[pick]  = 1'b1;
                            pinsn[pick] = slot[b][k];
                            psrc[pick]  = BIDX_W'(b);
                            done[b][k]  = 1'b1;
                            if (tdec[b].stop[k]) halt = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bdu_top.sv
module bdu_top
    import bdu_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int TMPL_W = 5,
    parameter int N_MEM  = 2,
    parameter int N_INT  = 2,
    parameter int N_FLT  = 2,
    parameter int N_BRN  = 3,
    localparam int NSLOT  = 3,
    localparam int NBUN   = 2,
    localparam int NPORT  = N_MEM + N_INT + N_FLT + N_BRN,
    localparam int BUN_W  = TMPL_W + NSLOT * SLOT_W,
    localparam int BIDX_W = $clog2(NBUN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUN_W-1:0]          bun0,
    input  logic [BUN_W-1:0]          bun1,
    input  logic [NBUN-1:0]           bun_vld,
    input  logic [NPORT-1:0]          port_free,
    output logic [NPORT-1:0]          port_vld,
    output logic [NPORT*SLOT_W-1:0]   port_insn,
    output logic [NPORT*BIDX_W-1:0]   port_src,
    output logic [1:0]                win_adv,
    output logic                      bun_err
);
    logic [NBUN-1:0][BUN_W-1:0]               win;
    tmpl_t [NBUN-1:0]                         tdec;
    logic [NBUN-1:0][NSLOT-1:0][SLOT_W-1:0]   slot;
    logic [NBUN-1:0][NSLOT-1:0]               done;
    logic [NPORT-1:0][SLOT_W-1:0]             pinsn;
    logic [NPORT-1:0][BIDX_W-1:0]             psrc;
    logic [NSLOT-1:0]                         mask_q, mask_n, resume;
    disp_st_e                                 state_q, state_n;
    logic                                     bad_head, head_full, both_full;

    assign win[0] = bun0;
    assign win[1] = bun1;

    for (genvar b = 0; b < NBUN; b++) begin : g_bun
        bdu_tmpl_dec #(.TMPL_W(TMPL_W)) u_dec (
            .code (win[b][TMPL_W-1:0]),
            .dec  (tdec[b])
        );
        for (genvar k = 0; k < NSLOT; k++) begin : g_slot
            assign slot[b][k] = win[b][TMPL_W + k*SLOT_W +: SLOT_W];
        end
    end

    bdu_slot_steer #(
        .SLOT_W(SLOT_W), .NSLOT(NSLOT), .NBUN(NBUN),
        .N_MEM(N_MEM), .N_INT(N_INT), .N_FLT(N_FLT), .N_BRN(N_BRN)
    ) u_steer (
        .bvld     (bun_vld),
        .tdec     (tdec),
        .slot     (slot),
        .resume   (resume),
        .free     (port_free),
        .pvld     (port_vld),
        .pinsn    (pinsn),
        .psrc     (psrc),
        .done     (done),
        .bad_head (bad_head)
    );

    assign port_insn = pinsn;
    assign port_src  = psrc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            mask_q  <= '0;
        end else begin
            state_q <= state_n;
            mask_q  <= mask_n;
        end
    end

    // outputs and next state
    always_comb begin
        unique case (state_q)
            ST_CLEAN:   resume = '0;
            ST_PARTIAL: resume = mask_q;
            default:    resume = '0;
        endcase
        head_full = bun_vld[0] && (&done[0]);
        both_full = head_full && bun_vld[1] && (&done[1]);
        bun_err   = bad_head;
        if (bad_head) begin
            win_adv = 2'd1;
            mask_n  = '0;
        end else if (both_full) begin
            win_adv = 2'd2;
            mask_n  = '0;
        end else if (head_full) begin
            win_adv = 2'd1;
            mask_n  = done[1];
        end else begin
            win_adv = 2'd0;
            mask_n  = bun_vld[0] ? done[0] : '0;
        end
        state_n = (mask_n != '0) ? ST_PARTIAL : ST_CLEAN;
    end

    logic b1_used;
    always_comb begin
        b1_used = 1'b0;
        for (int p = 0; p < NPORT; p++)
            if (port_vld[p] && psrc[p] != '0) b1_used = 1'b1;
    end

    p_free_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_vld & ~port_free) == '0);
    p_second_after_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b1_used |-> win_adv != 2'd0);
    p_err_retires_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bun_err |-> (win_adv == 2'd1 && port_vld == '0));
    p_invalid_head_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bun_vld[0] |-> (port_vld == '0 && win_adv == 2'd0));
    p_mask_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv == 2'd0 && bun_vld[0]) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
endmodule

// File: tb/test_bdu_top.sv
module test_bdu_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 9;
    localparam int NB = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [127:0]  bun0, bun1;
    logic [1:0]    bun_vld;
    logic [NP-1:0] port_free;
    logic [NP-1:0] port_vld;
    logic [NP*41-1:0] port_insn;
    logic [NP-1:0] port_src;
    logic [1:0]    win_adv;
    logic          bun_err;

    bdu_top i_bdu_top (
        .clk(clk), .rst_n(rst_n), .bun0(bun0), .bun1(bun1), .bun_vld(bun_vld),
        .port_free(port_free), .port_vld(port_vld), .port_insn(port_insn),
        .port_src(port_src), .win_adv(win_adv), .bun_err(bun_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // bench copy of the unit-kind table: 0 mem, 1 int, 2 float, 3 branch
    int kt[8][3] = '{'{0,1,1}, '{0,1,1}, '{0,0,1}, '{0,2,1},
                     '{0,0,2}, '{0,1,3}, '{0,3,3}, '{3,3,3}};
    int st[8]    = '{-1, 2, 1, -1, 2, -1, 0, 2};

    logic [127:0]  q[NB];
    int            head;
    bit [2:0]      tb_mask;
    logic [127:0]  w[2];
    bit [1:0]      v;

    bit [NP-1:0]    e_vld;
    logic [40:0]    e_insn[NP];
    bit [NP-1:0]    e_src;
    int             e_adv;
    bit             e_err;
    bit [2:0]       e_mask;
    string          tag;

    task automatic model();
        int base[4] = '{0, 2, 4, 6};
        int lim[4]  = '{2, 4, 6, 9};
        int nxt[4];
        bit [2:0] mb[2];
        bit halt;
        bit hf, bf;
        int code, c, p;
        for (int i = 0; i < 4; i++) nxt[i] = base[i];
        mb[0] = tb_mask; mb[1] = 3'b0;
        halt = 0; e_vld = '0; e_src = '0; e_err = 0;
        for (int i = 0; i < NP; i++) e_insn[i] = '0;
        tag = (tb_mask != 0) ? "R6" : "R3";
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 3; k++) begin
                if (!halt) begin
                    code = int'(w[b][4:0]);
                    if (!v[b]) begin
                        halt = 1; tag = "R10";
                    end else if (code > 7) begin
                        halt = 1;
                        if (b == 0) begin e_err = 1; tag = "R9"; end
                    end else if (!mb[b][k]) begin
                        c = kt[code][k];
                        p = nxt[c];
                        while (p < lim[c] && !port_free[p]) p++;
                        if (p >= lim[c]) begin
                            halt = 1; tag = "R5";
                        end else begin
                            e_vld[p] = 1; e_insn[p] = w[b][5+41*k +: 41];
                            e_src[p] = (b == 1); nxt[c] = p + 1; mb[b][k] = 1;
                            if (st[code] == k) begin halt = 1; tag = (code == 7) ? "R2" : "R4"; end
                        end
                    end
                end
            end
        end
        if (e_src != 0) tag = "R7";
        hf = v[0] && (mb[0] == 3'b111);
        bf = hf && v[1] && (mb[1] == 3'b111);
        if (e_err)    begin e_adv = 1; e_mask = 0; end
        else if (bf)  begin e_adv = 2; e_mask = 0; end
        else if (hf)  begin e_adv = 1; e_mask = mb[1]; end
        else          begin e_adv = 0; e_mask = v[0] ? mb[0] : 3'b0; end
    endtask

    task automatic check_cycle();
        model();
        checks++;
        if (port_vld !== e_vld) begin
            fails++;
            $display("FAIL %s port_vld actual=%b expected=%b", tag, port_vld, e_vld);
        end
        checks++;
        if (int'(win_adv) != e_adv || bun_err !== e_err) begin
            fails++;
            $display("FAIL %s adv/err actual=%0d/%0b expected=%0d/%0b",
                     e_err ? "R9" : "R8", win_adv, bun_err, e_adv, e_err);
        end
        for (int p = 0; p < NP; p++) begin
            if (e_vld[p]) begin
                checks++;
                if (port_insn[p*41 +: 41] !== e_insn[p]) begin
                    fails++;
                    $display("FAIL R1 port %0d insn actual=%h expected=%h", p, port_insn[p*41 +: 41], e_insn[p]);
                end
                checks++;
                if (port_src[p] !== e_src[p]) begin
                    fails++;
                    $display("FAIL R7 port %0d src actual=%b expected=%b", p, port_src[p], e_src[p]);
                end
            end
        end
    endtask

    task automatic gen(int pass);
        int r;
        logic [4:0] code;
        for (int i = 0; i < NB; i++) begin
            r = $urandom_range(0, 11);
            code = (r > 7) ? 5'($urandom_range(8, 31)) : 5'(r);
            q[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
            q[i][4:0] = code;
        end
        if (pass == 0) begin
            q[0][4:0] = 5'd6;   // stop after slot 0
            q[1][4:0] = 5'd19;  // reserved
            q[2][4:0] = 5'd7;   // three branches
            q[3][4:0] = 5'd2;
            q[4][4:0] = 5'd0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd2718));
        bun0 = '0; bun1 = '0; bun_vld = '0; port_free = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: nothing issued and nothing retired with an empty window
        checks++;
        if (port_vld !== '0 || win_adv !== 2'd0 || bun_err !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset outputs actual=%b/%0d/%b expected=0/0/0", port_vld, win_adv, bun_err);
        end
        tb_mask = 0;
        for (int pass = 0; pass < 6; pass++) begin
            gen(pass);
            head = 0;
            cyc = 0;
            while (head < NB && cyc < 2000) begin
                @(negedge clk);
                w[0] = q[head];
                w[1] = (head + 1 < NB) ? q[head+1] : '0;
                v[0] = 1'b1;
                v[1] = (head + 1 < NB) && ($urandom_range(0, 7) != 0);
                if (pass == 0 && cyc < 2)          port_free = '0;
                else if ($urandom_range(0, 3) == 0) port_free = '1;
                else                                port_free = NP'($urandom());
                bun0 = w[0]; bun1 = w[1]; bun_vld = v;
                #1;
                check_cycle();
                head += e_adv;
                tb_mask = e_mask;
                cyc++;
            end
        end
        @(negedge clk);
        bun_vld = '0;
        #1;
        checks++; // R10: empty window stays quiet
        if (port_vld !== '0 || win_adv !== 2'd0) begin
            fails++;
            $display("FAIL R10 empty window actual=%b/%0d expected=0/0", port_vld, win_adv);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule